// File: doc/BRIEF.md
# Descriptor Chain Queue Engine

This block runs one DMA channel, either transmit or receive. It walks a singly linked chain of buffer descriptors that sit in a local descriptor RAM. The host links descriptors in that RAM, sets the host-owned flag in each one, and writes the first descriptor's address to the head register. For each descriptor it owns, the engine offers the buffer address, the length and the packet framing flags to a simple data-mover port. When the mover reports the buffer done, the engine writes the status word back with ownership returned to the host. It then follows the next pointer.

When a descriptor has a null next pointer, the engine marks that descriptor as the end of the queue, clears the head register and goes idle. The host restarts a drained queue by writing the head register again. A completion register holds the host's acknowledgement of processed descriptors. In the receive variant, a free-buffer counter stops the engine from offering a buffer the host has not announced. A self-clearing soft reset returns the channel to a clean state.

Top module: `dq_engine`

## Requirements
- R1: A descriptor at word address P holds the next pointer at P+0, the buffer address at P+1, a length word at P+2 that the engine does not read, and the status word at P+3. In the status word, bit 31 is start-of-packet, bit 30 is end-of-packet, bit 29 is the host-owned flag, bit 28 is end-of-queue and bits 10:0 are the length. For each owned descriptor, one mover request carries the address from P+1, the length from bits 10:0 and the two framing flags. The engine reads and writes the RAM through one port and never does both in the same cycle.
- R2: The register word addresses are 0 control, 1 soft reset, 2 head, 3 completion and 4 free count. Writing a non-zero head while the engine is idle and enabled starts processing at that descriptor.
- R3: After the mover's done pulse, the engine writes the status word back with bit 29 cleared and bits 31:30 and 27:0 unchanged. It then continues with the descriptor named by the next pointer.
- R4: Bit 28 is set in the write-back only when the descriptor's next pointer is zero. The engine then stops and the head register reads zero.
- R5: After the queue has drained, writing the address of a newly appended descriptor to the head register restarts processing.
- R6: If the engine reaches a descriptor whose bit 29 is clear, it issues no mover request and leaves that descriptor unmodified. It clears the head register and goes idle.
- R7: A mover request, once offered, stays valid with stable address and length until it is accepted. The next request comes only after the done pulse.
- R8: Control bit 0 enables the channel. While it is 0, no new chain starts. If it is cleared during a chain, the current descriptor completes and the engine stops with the head register holding the next descriptor's address. Setting the bit again resumes from that descriptor.
- R9: A write to the head register while the engine is busy is ignored.
- R10: In the receive variant, a write to the free count adds the written value to it. Each completed descriptor takes one away. No mover request is offered while the count is zero.
- R11: Writing 1 to soft-reset bit 0 sets that bit for exactly one cycle. This clears the head, completion and free-count registers and returns the engine to idle.
- R12: The completion register reads back the last value the host wrote to it and has no effect on processing.
- R13: After reset, all five registers read zero and no mover request or RAM access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr, combinational |
| descRd | output | 1 | Descriptor RAM read; data returns one cycle later |
| descWr | output | 1 | Descriptor RAM write |
| descAddr | output | AW | Descriptor RAM word address |
| descWdata | output | 32 | Descriptor RAM write data |
| descRdata | input | 32 | Descriptor RAM read data |
| mvValid | output | 1 | Mover request valid |
| mvReady | input | 1 | Mover accepts the request |
| mvAddr | output | 32 | Buffer address |
| mvLen | output | 11 | Buffer length |
| mvSop | output | 1 | Start-of-packet flag |
| mvEop | output | 1 | End-of-packet flag |
| mvDone | input | 1 | One-cycle pulse, buffer finished |

## Verification
Some properties are checked on every cycle. A pending mover request must hold still, and the RAM port must never read and write together. Every write-back must carry a cleared owned flag, and a write-back flagged end-of-queue must leave the head at zero. No request may be offered against an empty free count, and a soft-reset pulse must clear the registers and drop itself. Other behaviour only the scenarios can show. These cover the exact order and content of transfers along a chain, with backpressure, and a restart after drain. They also cover the halt at a descriptor boundary and its resume, the stall and release on the free count, a skipped unowned descriptor, and a head write ignored while the engine is busy.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int SOP_BIT = 31;
  localparam int EOP_BIT = 30;
  localparam int OWN_BIT = 29;
  localparam int EOQ_BIT = 28;
  localparam int LEN_W   = 11;

  // word offsets inside one descriptor
  localparam logic [1:0] W_NEXT = 2'd0;
  localparam logic [1:0] W_BUF  = 2'd1;
  localparam logic [1:0] W_MODE = 2'd3;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_SRST = 3'd1;
  localparam logic [2:0] REG_HEAD = 3'd2;
  localparam logic [2:0] REG_CPL  = 3'd3;
  localparam logic [2:0] REG_FREE = 3'd4;

  typedef struct packed {
    logic       capMode;   // latch status word from RAM
    logic       capBuf;    // latch buffer address
    logic       capNext;   // latch next pointer
    logic       takeNext;  // head <= next pointer
    logic       dropHead;  // head <= 0 (unowned descriptor)
    logic       useFree;   // consume one free buffer
    logic [1:0] wordSel;   // descriptor word for RAM access
  } ctlStrobe_t;
endpackage

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
#(
  parameter bit RX_MODE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       srst,
  input  logic       enable,
  input  logic       headNz,
  input  logic       nextNz,
  input  logic       freeNz,
  input  logic       ownIn,
  input  logic       mvReady,
  input  logic       mvDone,
  output ctlStrobe_t stb,
  output logic       descRd,
  output logic       descWr,
  output logic       mvValid,
  output logic       busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LMODE, S_LBUF, S_LNEXT, S_XFER, S_WAIT, S_WBACK
  } state_e;

  state_e state, stateNxt;
  logic   offerOk;

  generate
    if (RX_MODE) begin : g_rxGate
      assign offerOk = freeNz;
    end else begin : g_txGate
      assign offerOk = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= S_IDLE;
    else if (srst) state <= S_IDLE;
    else           state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    descRd   = 1'b0;
    descWr   = 1'b0;
    mvValid  = 1'b0;
    unique case (state)
      S_IDLE:  if (headNz && enable) stateNxt = S_FETCH;
      S_FETCH: begin
        descRd      = 1'b1;
        stb.wordSel = W_MODE;
        stateNxt    = S_LMODE;
      end
      S_LMODE: begin
        stb.capMode = 1'b1;
        if (ownIn) begin
          descRd      = 1'b1;
          stb.wordSel = W_BUF;
          stateNxt    = S_LBUF;
        end else begin
          stb.dropHead = 1'b1;
          stateNxt     = S_IDLE;
        end
      end
      S_LBUF: begin
        stb.capBuf  = 1'b1;
        descRd      = 1'b1;
        stb.wordSel = W_NEXT;
        stateNxt    = S_LNEXT;
      end
      S_LNEXT: begin
        stb.capNext = 1'b1;
        stateNxt    = S_XFER;
      end
      S_XFER: begin
        mvValid = offerOk;
        if (offerOk && mvReady) stateNxt = S_WAIT;
      end
      S_WAIT:  if (mvDone) stateNxt = S_WBACK;
      S_WBACK: begin
        descWr       = 1'b1;
        stb.wordSel  = W_MODE;
        stb.takeNext = 1'b1;
        stb.useFree  = RX_MODE;
        stateNxt     = (nextNz && enable) ? S_FETCH : S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/dq_datapath.sv
module dq_datapath
  import dq_pkg::*;
#(
  parameter int AW     = 8,
  parameter int FREE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  ctlStrobe_t        stb,
  input  logic              busy,
  input  logic [31:0]       descRdata,
  output logic [AW-1:0]     descAddr,
  output logic [31:0]       descWdata,
  output logic [31:0]       mvAddr,
  output logic [LEN_W-1:0]  mvLen,
  output logic              mvSop,
  output logic              mvEop,
  output logic              srstBit,
  output logic              ctrlEn,
  output logic [31:0]       headPtr,
  output logic [FREE_W-1:0] freeCnt,
  output logic              nextNz
);
  logic [31:0] cplPtr, modeReg, bufReg, nextReg;
  logic        wrCtrl, wrSrst, wrHead, wrCpl, wrFree;
  logic [FREE_W-1:0] freeAdd;

  assign wrCtrl = regWr && (regAddr == REG_CTRL);
  assign wrSrst = regWr && (regAddr == REG_SRST);
  assign wrHead = regWr && (regAddr == REG_HEAD) && !busy && !srstBit;
  assign wrCpl  = regWr && (regAddr == REG_CPL);
  assign wrFree = regWr && (regAddr == REG_FREE);
  assign freeAdd = wrFree ? regWdata[FREE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      srstBit <= 1'b0;
    end else begin
      if (wrCtrl) ctrlEn <= regWdata[0];
      srstBit <= wrSrst && regWdata[0] && !srstBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      cplPtr  <= '0;
      freeCnt <= '0;
    end else if (srstBit) begin
      headPtr <= '0;
      cplPtr  <= '0;
      freeCnt <= '0;
    end else begin
      if (stb.dropHead)      headPtr <= '0;
      else if (stb.takeNext) headPtr <= nextReg;
      else if (wrHead)       headPtr <= regWdata;
      if (wrCpl) cplPtr <= regWdata;
      freeCnt <= freeCnt + freeAdd - FREE_W'(stb.useFree);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      bufReg  <= '0;
      nextReg <= '0;
    end else begin
      if (stb.capMode) modeReg <= descRdata;
      if (stb.capBuf)  bufReg  <= descRdata;
      if (stb.capNext) nextReg <= descRdata;
    end
  end

  assign nextNz   = (nextReg != '0);
  assign descAddr = headPtr[AW-1:0] + AW'(stb.wordSel);

  always_comb begin
    descWdata          = modeReg;
    descWdata[OWN_BIT] = 1'b0;
    descWdata[EOQ_BIT] = !nextNz;
  end

  assign mvAddr = bufReg;
  assign mvLen  = modeReg[LEN_W-1:0];
  assign mvSop  = modeReg[SOP_BIT];
  assign mvEop  = modeReg[EOP_BIT];

  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdata = {31'b0, ctrlEn};
      REG_SRST: regRdata = {31'b0, srstBit};
      REG_HEAD: regRdata = headPtr;
      REG_CPL:  regRdata = cplPtr;
      REG_FREE: regRdata = 32'(freeCnt);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dq_engine.sv
module dq_engine
  import dq_pkg::*;
#(
  parameter int AW      = 8,
  parameter int FREE_W  = 16,
  parameter bit RX_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             descRd,
  output logic             descWr,
  output logic [AW-1:0]    descAddr,
  output logic [31:0]      descWdata,
  input  logic [31:0]      descRdata,
  output logic             mvValid,
  input  logic             mvReady,
  output logic [31:0]      mvAddr,
  output logic [LEN_W-1:0] mvLen,
  output logic             mvSop,
  output logic             mvEop,
  input  logic             mvDone
);
  ctlStrobe_t        stb;
  logic              busy, srstBit, ctrlEn, nextNz;
  logic [31:0]       headPtr;
  logic [FREE_W-1:0] freeCnt;

  dq_ctrl #(.RX_MODE(RX_MODE)) uCtrl (
    .clk(clk), .rstN(rstN), .srst(srstBit), .enable(ctrlEn),
    .headNz(headPtr != '0), .nextNz(nextNz), .freeNz(freeCnt != '0),
    .ownIn(descRdata[OWN_BIT]), .mvReady(mvReady), .mvDone(mvDone),
    .stb(stb), .descRd(descRd), .descWr(descWr), .mvValid(mvValid),
    .busy(busy)
  );

  dq_datapath #(.AW(AW), .FREE_W(FREE_W)) uDp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .busy(busy),
    .descRdata(descRdata), .descAddr(descAddr), .descWdata(descWdata),
    .mvAddr(mvAddr), .mvLen(mvLen), .mvSop(mvSop), .mvEop(mvEop),
    .srstBit(srstBit), .ctrlEn(ctrlEn), .headPtr(headPtr),
    .freeCnt(freeCnt), .nextNz(nextNz)
  );
endmodule

// File: rtl/dq_engine_chk.sv
module dq_engine_chk #(
  parameter int FREE_W  = 16,
  parameter bit RX_MODE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              srstBit,
  input logic              mvValid,
  input logic              mvReady,
  input logic [31:0]       mvAddr,
  input logic [10:0]       mvLen,
  input logic              descRd,
  input logic              descWr,
  input logic [31:0]       descWdata,
  input logic [31:0]       headPtr,
  input logic [FREE_W-1:0] freeCnt
);
  // R7: a pending request holds still until accepted
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (mvValid && !mvReady && !srstBit) |=> (mvValid && $stable(mvAddr) && $stable(mvLen)));

  // R1: single RAM port, never read and write together
  a_r1_single_access: assert property (@(posedge clk) disable iff (!rstN)
    !(descRd && descWr));

  // R3: every write-back hands ownership to the host
  a_r3_owner_returned: assert property (@(posedge clk) disable iff (!rstN)
    descWr |-> !descWdata[29]);

  // R4: end-of-queue write-back leaves the queue drained
  a_r4_eoq_drains: assert property (@(posedge clk) disable iff (!rstN)
    (descWr && descWdata[28]) |=> (headPtr == '0));

  // R10: nothing offered against an empty free count
  a_r10_no_offer_empty: assert property (@(posedge clk) disable iff (!rstN)
    (mvValid && RX_MODE) |-> (freeCnt != '0));

  // R11: soft reset clears state and drops itself
  a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rstN)
    srstBit |=> (!srstBit && headPtr == '0 && freeCnt == '0));
endmodule

bind dq_engine dq_engine_chk #(.FREE_W(FREE_W), .RX_MODE(RX_MODE)) uChk (
  .clk(clk), .rstN(rstN), .srstBit(srstBit), .mvValid(mvValid),
  .mvReady(mvReady), .mvAddr(mvAddr), .mvLen(mvLen), .descRd(descRd),
  .descWr(descWr), .descWdata(descWdata), .headPtr(headPtr),
  .freeCnt(freeCnt)
);

// File: tb/sim_dq_engine.sv
`timescale 1ns/1ps
module sim_dq_engine;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        descRd, descWr;
  logic [AW-1:0] descAddr;
  logic [31:0] descWdata;
  logic [31:0] descRdata = '0;
  logic        mvValid;
  logic        mvReady = 1'b1;
  logic [31:0] mvAddr;
  logic [10:0] mvLen;
  logic        mvSop, mvEop;
  logic        mvDone = 1'b0;

  int checks = 0;
  int failures = 0;
  int xferCount = 0;
  int stallCnt = 0;
  int doneCnt = 0;
  bit finished = 0;

  logic [31:0] mem [0:(1<<AW)-1];
  logic [31:0] expAddr[$];
  logic [10:0] expLen[$];
  logic        expSop[$];
  logic        expEop[$];

  always #10 clk = ~clk;

  dq_engine u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .descRd(descRd),
    .descWr(descWr), .descAddr(descAddr), .descWdata(descWdata),
    .descRdata(descRdata), .mvValid(mvValid), .mvReady(mvReady),
    .mvAddr(mvAddr), .mvLen(mvLen), .mvSop(mvSop), .mvEop(mvEop),
    .mvDone(mvDone)
  );

  // descriptor RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (descWr) mem[descAddr] = descWdata;
    if (descRd) descRdata <= mem[descAddr];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // mover model: backpressure, request compare against the reference queue, done pulse
  initial begin
    forever begin
      @(negedge clk);
      mvDone = 1'b0;
      if (doneCnt > 0) begin
        doneCnt--;
        if (doneCnt == 0) mvDone = 1'b1;
      end
      if (mvValid && stallCnt > 0) begin
        stallCnt--;
        mvReady = 1'b0;
      end else begin
        mvReady = 1'b1;
      end
      if (rstN && mvValid && mvReady) begin
        xferCount++;
        doneCnt = 2;
        if (expAddr.size() == 0) begin
          chk(1'b0, "R1 unexpected mover request", mvAddr, 32'h0);
        end else begin
          chkEq("R1 mover address", mvAddr, expAddr.pop_front());
          chkEq("R1 mover length", {21'b0, mvLen}, {21'b0, expLen.pop_front()});
          chkEq("R1 mover sop/eop", {30'b0, mvSop, mvEop},
                {30'b0, expSop.pop_front(), expEop.pop_front()});
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  function automatic logic [31:0] mkMode(input bit sop, input bit eop, input bit own,
                                         input logic [10:0] len, input logic [31:0] extra);
    return (32'(sop) << 31) | (32'(eop) << 30) | (32'(own) << 29) | extra | {21'b0, len};
  endfunction

  function automatic logic [31:0] doneMode(input logic [31:0] m, input bit last);
    return (m & ~(32'h1 << 29) & ~(32'h1 << 28)) | (last ? (32'h1 << 28) : 32'h0);
  endfunction

  task automatic mkDesc(input int p, input int nxt, input logic [31:0] buff, input logic [31:0] mode);
    mem[p]   = nxt;
    mem[p+1] = buff;
    mem[p+2] = 32'hdead_0000;
    mem[p+3] = mode;
  endtask

  task automatic expectOne(input int p);
    expAddr.push_back(mem[p+1]);
    expLen.push_back(mem[p+3][10:0]);
    expSop.push_back(mem[p+3][31]);
    expEop.push_back(mem[p+3][30]);
  endtask

  task automatic expectChain(input int head);
    int p = head;
    while (p != 0 && mem[p+3][29]) begin
      expectOne(p);
      p = mem[p];
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] m16, m32, m48, m64, m80;
    int xBefore;
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    cyc(5);
    rstN = 1'b1;
    cyc(2);

    // R13: reset state
    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), v);
      chkEq("R13 register reads zero after reset", v, 32'h0);
    end
    chkEq("R13 no activity after reset", {29'b0, mvValid, descRd, descWr}, 32'h0);

    // R1 R2 R3 R4 R7 R10: three-descriptor chain with backpressure
    m16 = mkMode(1, 0, 1, 11'd60, 32'h0);
    m32 = mkMode(0, 0, 1, 11'd100, 32'h0000_8000);
    m48 = mkMode(0, 1, 1, 11'd1514, 32'h0);
    mkDesc(16, 32, 32'h0000_1000, m16);
    mkDesc(32, 48, 32'h0000_2000, m32);
    mkDesc(48, 0, 32'h0000_3000, m48);
    wreg(dq_pkg::REG_CTRL, 32'h1);
    wreg(dq_pkg::REG_FREE, 32'd5);
    expectChain(16);
    stallCnt = 3;
    wreg(dq_pkg::REG_HEAD, 32'd16);
    cyc(100);
    chkEq("R2 all chain requests issued", expAddr.size(), 0);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R4 head drained to zero", v, 32'h0);
    rreg(dq_pkg::REG_FREE, v);
    chkEq("R10 free count decremented per descriptor", v, 32'd2);
    chkEq("R3 first write-back", mem[19], doneMode(m16, 0));
    chkEq("R3 middle write-back keeps other bits", mem[35], doneMode(m32, 0));
    chkEq("R4 last write-back has end-of-queue", mem[51], doneMode(m48, 1));

    // R5: restart after drain with an appended descriptor
    m64 = mkMode(1, 1, 1, 11'd77, 32'h0);
    mkDesc(64, 0, 32'h0000_4000, m64);
    mem[48] = 64;
    expectChain(64);
    wreg(dq_pkg::REG_HEAD, 32'd64);
    cyc(60);
    chkEq("R5 restarted descriptor issued", expAddr.size(), 0);
    chkEq("R5 restarted descriptor written back", mem[67], doneMode(m64, 1));
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R5 head drained after restart", v, 32'h0);

    // R6: unowned descriptor
    m80 = mkMode(1, 1, 0, 11'd33, 32'h0001_0000);
    mkDesc(80, 16, 32'h0000_5000, m80);
    xBefore = xferCount;
    wreg(dq_pkg::REG_HEAD, 32'd80);
    cyc(30);
    chkEq("R6 no request for unowned descriptor", xferCount, xBefore);
    chkEq("R6 unowned descriptor unmodified", mem[83], m80);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R6 head cleared", v, 32'h0);

    // R10: stall on empty free count, release by a free write
    mkDesc(96, 112, 32'h0000_6000, mkMode(1, 0, 1, 11'd64, 32'h0));
    mkDesc(112, 0, 32'h0000_7000, mkMode(0, 1, 1, 11'd65, 32'h0));
    expectChain(96);
    xBefore = xferCount;
    wreg(dq_pkg::REG_HEAD, 32'd96);
    cyc(60);
    chkEq("R10 only one request while free count ran out", xferCount, xBefore + 1);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R10 stalled on second descriptor", v, 32'd112);
    wreg(dq_pkg::REG_FREE, 32'd1);
    cyc(60);
    chkEq("R10 released after free write", expAddr.size(), 0);
    rreg(dq_pkg::REG_FREE, v);
    chkEq("R10 free count back to zero", v, 32'h0);

    // R8: disabled channel does not start, halt at a boundary, resume
    wreg(dq_pkg::REG_CTRL, 32'h0);
    wreg(dq_pkg::REG_FREE, 32'd4);
    mkDesc(128, 144, 32'h0000_8000, mkMode(1, 0, 1, 11'd200, 32'h0));
    mkDesc(144, 0, 32'h0000_9000, mkMode(0, 1, 1, 11'd201, 32'h0));
    xBefore = xferCount;
    wreg(dq_pkg::REG_HEAD, 32'd128);
    cyc(30);
    chkEq("R8 disabled channel issues nothing", xferCount, xBefore);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R8 head kept while disabled", v, 32'd128);
    expectOne(128);
    stallCnt = 5;
    wreg(dq_pkg::REG_CTRL, 32'h1);
    wreg(dq_pkg::REG_CTRL, 32'h0);
    cyc(60);
    chkEq("R8 current descriptor completed", expAddr.size(), 0);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R8 halted at next descriptor", v, 32'd144);
    expectOne(144);
    wreg(dq_pkg::REG_CTRL, 32'h1);
    cyc(60);
    chkEq("R8 resumed after enable", expAddr.size(), 0);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R8 drained after resume", v, 32'h0);

    // R9: head write while busy is ignored
    mkDesc(160, 0, 32'h0000_a000, mkMode(1, 1, 1, 11'd90, 32'h0));
    mkDesc(176, 0, 32'h0000_b000, mkMode(1, 1, 1, 11'd91, 32'h0));
    expectOne(160);
    stallCnt = 6;
    wreg(dq_pkg::REG_HEAD, 32'd160);
    wreg(dq_pkg::REG_HEAD, 32'd176);
    cyc(60);
    chkEq("R9 only the first chain ran", expAddr.size(), 0);
    chkEq("R9 ignored descriptor still host-owned", {31'b0, mem[179][29]}, 32'h1);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R9 head drained", v, 32'h0);

    // R12: completion register
    xBefore = xferCount;
    wreg(dq_pkg::REG_CPL, 32'd160);
    rreg(dq_pkg::REG_CPL, v);
    chkEq("R12 completion reads back", v, 32'd160);
    cyc(10);
    chkEq("R12 completion write starts nothing", xferCount, xBefore);

    // R11: soft reset
    wreg(dq_pkg::REG_CTRL, 32'h0);
    wreg(dq_pkg::REG_FREE, 32'd7);
    wreg(dq_pkg::REG_HEAD, 32'd176);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R11 head loaded before soft reset", v, 32'd176);
    wreg(dq_pkg::REG_SRST, 32'h1);
    rreg(dq_pkg::REG_SRST, v);
    chkEq("R11 soft reset bit self-cleared", v, 32'h0);
    rreg(dq_pkg::REG_HEAD, v);
    chkEq("R11 head cleared", v, 32'h0);
    rreg(dq_pkg::REG_CPL, v);
    chkEq("R11 completion cleared", v, 32'h0);
    rreg(dq_pkg::REG_FREE, v);
    chkEq("R11 free count cleared", v, 32'h0);
    xBefore = xferCount;
    wreg(dq_pkg::REG_CTRL, 32'h1);
    cyc(20);
    chkEq("R11 nothing runs after soft reset", xferCount, xBefore);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule